// File: doc/BRIEF.md
# Interrupt Gate Descriptor Checker

This block sits between the front end that raises an interrupt event and the sequencer that carries out the transfer of control. Each request names the vector, what raised it, the current operating mode, the current privilege level and the limit of the interrupt descriptor table. The source is one of four kinds: an external event, a numbered software interrupt, the one-byte breakpoint interrupt, or the overflow-trap instruction. The modes are real, protected and 64-bit long mode.

The block computes the byte offset of the table entry and first checks it against the limit. When the entry lies inside the limit, the block reads it through a valid/ready read port. The entry is then validated in a fixed order. The block returns exactly one result per accepted request. A result is one of three things:

- a fault, with its class and error code;
- a task-gate dispatch, with the selector;
- a trap/interrupt-gate dispatch, with the selector, the offset and an optional alternate stack index.

Top module: `igate_check`

## Requirements
- R1: During and after a synchronous reset, `res_valid` and `rd_valid` are 0 and `req_ready` is 1.
- R2: The entry is 4 bytes in mode 0 (real), 8 bytes in mode 1 (protected) and 16 bytes in mode 2 (long). `rd_addr` equals vector × entry size.
- R3: Real mode makes no checks. The result is a gate dispatch (`res_kind`=2) with the selector from data[31:16] and the offset from data[15:0], zero-extended. Higher data bits are ignored.
- R4: In protected or long mode, when vector×size+size−1 exceeds `req_limit`, the block raises a general-protection fault (`res_kind`=0, `res_fault`=0). The error code is vector×size+2+EXT. No read is issued. EXT is 1 only for source 0 (external); sources 1, 2 and 3 are numbered, breakpoint and overflow-trap.
- R5: In protected mode the gate type in data[43:40] must be 5 (task), 6 or 14 (interrupt), or 7 or 15 (trap). Any other type raises a general-protection fault with error code vector×8+2+EXT.
- R6: For a software source (1, 2 or 3) whose gate privilege data[46:45] is below `req_cpl`, the block raises a general-protection fault. Its error code is vector×size+2 with EXT never added. External events skip this check.
- R7: A clear present bit data[47] raises a not-present fault (`res_fault`=1) with error code vector×size+2+EXT. This check is made only after the checks of R4, R5, R6 and R10 have passed.
- R8: A valid type-5 gate gives a task dispatch (`res_kind`=1) with the selector from data[31:16]. A valid interrupt or trap gate gives a gate dispatch with that selector. In protected mode the offset is {data[63:48], data[15:0]}.
- R9: In long mode only types 14 and 15 are valid. Any other type, including a task gate, raises a general-protection fault with error code vector×16+2+EXT. The offset is {data[95:64], data[63:48], data[15:0]}.
- R10: In long mode an overflow-trap source (3) that passes the limit and type checks raises an invalid-opcode fault (`res_fault`=2) with `res_err_vld`=0. No privilege or present check follows.
- R11: In long mode a non-zero stack index in data[34:32] sets `res_ist_vld` and gives that index on `res_ist`. In protected and real mode `res_ist_vld` stays 0.
- R12: Each accepted request yields exactly one single-cycle `res_valid` pulse. `req_ready` is 0 from acceptance until the result.
- R13: For faults and task dispatch, the offset and stack fields are zero. For every result other than a fault, `res_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_vector | input | 8 | Interrupt vector |
| req_src | input | 2 | Source: 0 external, 1 numbered, 2 breakpoint, 3 overflow trap |
| req_mode | input | 2 | Mode: 0 real, 1 protected, 2 long |
| req_cpl | input | 2 | Current privilege level |
| req_limit | input | 16 | Descriptor table limit in bytes |
| rd_valid | output | 1 | Entry read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 12 | Byte offset of the entry |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 128 | Entry contents |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 0 fault, 1 task dispatch, 2 gate dispatch |
| res_fault | output | 2 | 0 general protection, 1 not present, 2 invalid opcode |
| res_err_vld | output | 1 | Error code present |
| res_err_code | output | 16 | Fault error code |
| res_sel | output | 16 | Target selector |
| res_off | output | 64 | Target offset |
| res_ist_vld | output | 1 | Alternate stack requested |
| res_ist | output | 3 | Alternate stack slot index |

## Verification
A context register that loses the latched mode or vector would show on `rd_addr` in the cycle after acceptance. It would also show in the error code of the result that follows one cycle after the read response. A wrong check order cannot be seen from well-formed entries. It appears only when an entry breaks two rules at once, so the bench pairs a privilege failure with a clear present bit, and a long-mode overflow trap with a bad type. If the sequencer stays busy or returns early, `req_ready` shows it in the cycle after acceptance. A pulse with no pending expectation is flagged at once.

// File: rtl/igate_pkg.sv
package igate_pkg;

    localparam int VEC_W  = 8;
    localparam int LIM_W  = 16;
    localparam int ERR_W  = 16;
    localparam int SEL_W  = 16;
    localparam int OFF_W  = 64;
    localparam int IST_W  = 3;
    localparam int DESC_W = 128;
    localparam int ADDR_W = VEC_W + 4;   // room for vector * 16 + 15

    // descriptor field positions
    localparam int F_OFF0_LO = 0;
    localparam int F_SEL_LO  = 16;
    localparam int F_IST_LO  = 32;
    localparam int F_TYPE_LO = 40;
    localparam int F_DPL_LO  = 45;
    localparam int F_P       = 47;
    localparam int F_OFF1_LO = 48;
    localparam int F_OFF2_LO = 64;

    localparam logic [3:0] GT_TASK   = 4'h5;
    localparam logic [3:0] GT_INT16  = 4'h6;
    localparam logic [3:0] GT_TRAP16 = 4'h7;
    localparam logic [3:0] GT_INT    = 4'hE;
    localparam logic [3:0] GT_TRAP   = 4'hF;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_NUM  = 2'd1,
        SRC_BRK  = 2'd2,
        SRC_OVF  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_LONG = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        KIND_FAULT = 2'd0,
        KIND_TASK  = 2'd1,
        KIND_GATE  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        FLT_GP = 2'd0,
        FLT_NP = 2'd1,
        FLT_UD = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        src_e             src;
        mode_e            mode;
        logic [1:0]       cpl;
        logic [LIM_W-1:0] limit;
    } ctx_t;

    typedef struct packed {
        kind_e            kind;
        fault_e           fault;
        logic             err_vld;
        logic [ERR_W-1:0] err;
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
        logic             ist_vld;
        logic [IST_W-1:0] ist;
    } res_t;

    // log2 of entry size per mode; the reserved mode behaves as protected
    function automatic int unsigned entry_shift(mode_e m);
        case (m)
            MODE_REAL: return 2;
            MODE_LONG: return 4;
            default:   return 3;
        endcase
    endfunction

    function automatic logic is_soft(src_e s);
        return s != SRC_EXT;
    endfunction

endpackage

// File: rtl/igate_addr.sv
module igate_addr
    import igate_pkg::*;
(
    input  ctx_t              ctx,
    output logic [ADDR_W-1:0] addr,
    output logic              limit_ok
);
    int unsigned       sh;
    logic [ADDR_W-1:0] last;
    logic              unused_ctx;

    assign unused_ctx = ^{ctx.src, ctx.cpl};

    always_comb begin
        sh   = entry_shift(ctx.mode);
        addr = ADDR_W'(ctx.vector) << sh;
        last = addr + ADDR_W'((32'd1 << sh) - 32'd1);
        if (ctx.mode == MODE_REAL)
            limit_ok = 1'b1;
        else
            limit_ok = (32'(last) <= 32'(ctx.limit));
    end
endmodule

// File: rtl/igate_eval.sv
module igate_eval
    import igate_pkg::*;
(
    input  ctx_t              ctx,
    input  logic [ADDR_W-1:0] addr,
    input  logic              limit_ok,
    input  logic [DESC_W-1:0] desc,
    output res_t              res
);
    logic [3:0]       dtype;
    logic [1:0]       dpl;
    logic             present;
    logic             is_long;
    logic             type_ok;
    logic             ext;
    logic [ERR_W-1:0] err_base;
    logic [ERR_W-1:0] err_ext;
    logic [IST_W-1:0] ist_f;
    logic             unused_bits;

    assign unused_bits = ^{desc[DESC_W-1:F_OFF2_LO+32], desc[F_TYPE_LO-1:F_IST_LO+IST_W],
                           desc[F_TYPE_LO+4], ctx.limit};

    always_comb begin
        dtype    = desc[F_TYPE_LO +: 4];
        dpl      = desc[F_DPL_LO +: 2];
        present  = desc[F_P];
        ist_f    = desc[F_IST_LO +: IST_W];
        is_long  = (ctx.mode == MODE_LONG);
        ext      = (ctx.src == SRC_EXT);
        err_base = ERR_W'(addr) + ERR_W'(2);
        err_ext  = err_base | ERR_W'(ext);
        if (is_long)
            type_ok = (dtype == GT_INT) || (dtype == GT_TRAP);
        else
            type_ok = (dtype == GT_TASK) || (dtype == GT_INT16) || (dtype == GT_TRAP16) ||
                      (dtype == GT_INT) || (dtype == GT_TRAP);

        res       = '0;
        res.kind  = KIND_FAULT;
        res.fault = FLT_GP;
        if (ctx.mode == MODE_REAL) begin
            res.kind = KIND_GATE;
            res.sel  = desc[F_SEL_LO +: SEL_W];
            res.off  = OFF_W'(desc[F_OFF0_LO +: 16]);
        end else if (!limit_ok || !type_ok) begin
            res.err_vld = 1'b1;
            res.err     = err_ext;
        end else if (is_long && ctx.src == SRC_OVF) begin
            res.fault = FLT_UD;
        end else if (is_soft(ctx.src) && (dpl < ctx.cpl)) begin
            res.err_vld = 1'b1;
            res.err     = err_base;
        end else if (!present) begin
            res.fault   = FLT_NP;
            res.err_vld = 1'b1;
            res.err     = err_ext;
        end else if (dtype == GT_TASK) begin
            res.kind = KIND_TASK;
            res.sel  = desc[F_SEL_LO +: SEL_W];
        end else begin
            res.kind = KIND_GATE;
            res.sel  = desc[F_SEL_LO +: SEL_W];
            if (is_long) begin
                res.off     = {desc[F_OFF2_LO +: 32], desc[F_OFF1_LO +: 16], desc[F_OFF0_LO +: 16]};
                res.ist_vld = (ist_f != '0);
                res.ist     = ist_f;
            end else begin
                res.off = OFF_W'({desc[F_OFF1_LO +: 16], desc[F_OFF0_LO +: 16]});
            end
        end
    end
endmodule

// File: rtl/igate_check.sv
module igate_check
    import igate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [1:0]        req_src,
    input  logic [1:0]        req_mode,
    input  logic [1:0]        req_cpl,
    input  logic [LIM_W-1:0]  req_limit,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_resp_valid,
    input  logic [DESC_W-1:0] rd_resp_data,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [1:0]        res_fault,
    output logic              res_err_vld,
    output logic [ERR_W-1:0]  res_err_code,
    output logic [SEL_W-1:0]  res_sel,
    output logic [OFF_W-1:0]  res_off,
    output logic              res_ist_vld,
    output logic [IST_W-1:0]  res_ist
);
    state_e            state;
    ctx_t              ctx_live, ctx_hold, ctx_cur;
    logic [ADDR_W-1:0] addr;
    logic              lim_ok;
    logic              accept;
    res_t              eval_res, res_q;

    always_comb begin
        ctx_live.vector = req_vector;
        ctx_live.src    = src_e'(req_src);
        ctx_live.mode   = mode_e'(req_mode);
        ctx_live.cpl    = req_cpl;
        ctx_live.limit  = req_limit;
    end

    assign ctx_cur   = (state == ST_IDLE) ? ctx_live : ctx_hold;
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_valid  = (state == ST_REQ);
    assign rd_addr   = addr;

    igate_addr u_addr (
        .ctx      (ctx_cur),
        .addr     (addr),
        .limit_ok (lim_ok)
    );

    igate_eval u_eval (
        .ctx      (ctx_cur),
        .addr     (addr),
        .limit_ok (lim_ok),
        .desc     (rd_resp_data),
        .res      (eval_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx_hold  <= '0;
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    ctx_hold <= ctx_live;
                    if (!lim_ok) begin
                        res_q     <= eval_res;
                        res_valid <= 1'b1;
                    end else begin
                        state <= ST_REQ;
                    end
                end
                ST_REQ: if (rd_ready) state <= ST_WAIT;
                ST_WAIT: if (rd_resp_valid) begin
                    res_q     <= eval_res;
                    res_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign res_kind     = res_q.kind;
    assign res_fault    = res_q.fault;
    assign res_err_vld  = res_q.err_vld;
    assign res_err_code = res_q.err;
    assign res_sel      = res_q.sel;
    assign res_off      = res_q.off;
    assign res_ist_vld  = res_q.ist_vld;
    assign res_ist      = res_q.ist;

    // R1: reset leaves the block idle with no result
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!res_valid && req_ready && !rd_valid));

    // R4: a limit failure answers at once without any read
    a_r4_no_read_on_limit: assert property (@(posedge clk) disable iff (rst)
        (accept && !lim_ok) |=> (res_valid && !rd_valid && req_ready));

    // R2: the read offset is a multiple of the entry size of the held mode
    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((ctx_hold.mode == MODE_REAL) ? (rd_addr[1:0] == 2'b0) :
                      (ctx_hold.mode == MODE_LONG) ? (rd_addr[3:0] == 4'b0) :
                                                     (rd_addr[2:0] == 3'b0)));

    // R12: no new request is taken while a read is outstanding
    a_r12_busy_refuses: assert property (@(posedge clk) disable iff (rst)
        (rd_valid || state == ST_WAIT) |-> !req_ready);

    // R10: the invalid-opcode fault carries no error code
    a_r10_ud_no_code: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd0 && res_fault == 2'd2) |-> !res_err_vld);

    // R11: a stack index only accompanies a gate dispatch and is non-zero
    a_r11_ist_on_gate: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ist_vld) |-> (res_kind == 2'd2 && res_ist != '0));

    // R12: a result pulse never coincides with an outstanding read
    a_r12_result_when_free: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (state == ST_IDLE));
endmodule

// File: tb/igate_check_tb.sv
module igate_check_tb;
    localparam int EW = 105;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [7:0]   req_vector = '0;
    logic [1:0]   req_src = '0;
    logic [1:0]   req_mode = '0;
    logic [1:0]   req_cpl = '0;
    logic [15:0]  req_limit = '0;
    logic         rd_valid;
    logic         rd_ready = 1'b1;
    logic [11:0]  rd_addr;
    logic         rd_resp_valid = 1'b0;
    logic [127:0] rd_resp_data = '0;
    logic         res_valid;
    logic [1:0]   res_kind;
    logic [1:0]   res_fault;
    logic         res_err_vld;
    logic [15:0]  res_err_code;
    logic [15:0]  res_sel;
    logic [63:0]  res_off;
    logic         res_ist_vld;
    logic [2:0]   res_ist;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    logic [127:0]  cur_desc = '0;
    int            exp_addr = 0;
    string         cur_tag = "";
    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    igate_check u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_src(req_src), .req_mode(req_mode),
        .req_cpl(req_cpl), .req_limit(req_limit),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .res_valid(res_valid), .res_kind(res_kind), .res_fault(res_fault),
        .res_err_vld(res_err_vld), .res_err_code(res_err_code),
        .res_sel(res_sel), .res_off(res_off),
        .res_ist_vld(res_ist_vld), .res_ist(res_ist)
    );

    function automatic logic [127:0] mk(logic [63:0] off, logic [15:0] sel, logic [2:0] ist,
                                        logic [3:0] typ, logic [1:0] dpl, logic p);
        logic [127:0] d = '0;
        d[15:0]   = off[15:0];
        d[31:16]  = sel;
        d[34:32]  = ist;
        d[43:40]  = typ;
        d[46:45]  = dpl;
        d[47]     = p;
        d[63:48]  = off[31:16];
        d[95:64]  = off[63:32];
        return d;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // memory responder: checks the offset, answers one cycle after the request
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rd_valid) begin
                reads++;
                chk({cur_tag, " R2 rd_addr"}, 128'(rd_addr), 128'(exp_addr));
                @(negedge clk);
                rd_resp_valid = 1'b1;
                rd_resp_data  = cur_desc;
                @(negedge clk);
                rd_resp_valid = 1'b0;
                rd_resp_data  = '0;
            end
        end
    end

    // monitor: pops one expectation per result pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R12 unexpected result", 128'(1), 128'(0));
                end else begin
                    logic [EW-1:0] e;
                    string         t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " result"},
                        128'({res_kind, res_fault, res_err_vld, res_err_code, res_sel,
                              res_off, res_ist_vld, res_ist}), 128'(e));
                end
            end
        end
    end

    task automatic run(string tag, int vec, int src, int mode, int cpl, int lim,
                       logic [127:0] d, int kind, int flt, bit errv, int err, int sel,
                       logic [63:0] off, bit istv, int ist, bit rd, int addr);
        int r0;
        exp_q.push_back({2'(kind), 2'(flt), errv, 16'(err), 16'(sel), off, istv, 3'(ist)});
        tag_q.push_back(tag);
        cur_desc = d;
        exp_addr = addr;
        cur_tag  = tag;
        r0 = reads;
        @(negedge clk);
        req_vector = 8'(vec);
        req_src    = 2'(src);
        req_mode   = 2'(mode);
        req_cpl    = 2'(cpl);
        req_limit  = 16'(lim);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        if (rd) chk({tag, " R12 busy"}, 128'(req_ready), 128'(0));
        wait (exp_q.size() == 0);
        @(negedge clk);
        chk({tag, " R4 read count"}, 128'(reads - r0), 128'(rd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 128'({res_valid, rd_valid, req_ready}), 128'(3'b001));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 128'({res_valid, rd_valid, req_ready}), 128'(3'b001));

        // R3 real mode: upper bits ignored, no checks even with limit 0
        run("R3 real", 'h10, 0, 0, 0, 0, mk(64'h0000_0000_AAAA_BEEF, 16'h1234, 0, 0, 0, 0),
            2, 0, 0, 0, 'h1234, 64'hBEEF, 0, 0, 1, 'h40);
        // R8 protected interrupt gate, 32-bit offset
        run("R8 prot gate", 'h21, 1, 1, 3, 'h7FF, mk(64'hFFFF_FFFF_1234_5678, 16'h0008, 0, 4'hE, 3, 1),
            2, 0, 0, 0, 'h8, 64'h1234_5678, 0, 0, 1, 'h108);
        // R4 boundary: last byte equal to limit passes
        run("R4 limit edge pass", 'h20, 0, 1, 0, 'h107, mk(64'h4000, 16'h0010, 0, 4'h7, 0, 1),
            2, 0, 0, 0, 'h10, 64'h4000, 0, 0, 1, 'h100);
        run("R4 limit fail", 'h20, 0, 1, 0, 'h106, mk(64'h4000, 16'h0010, 0, 4'h7, 0, 1),
            0, 0, 1, 'h103, 0, 64'h0, 0, 0, 0, 0);
        run("R5 bad type", 5, 0, 1, 0, 'h7FF, mk(64'h0, 16'h8, 0, 4'h3, 0, 1),
            0, 0, 1, 'h2B, 0, 64'h0, 0, 0, 1, 'h28);
        // R6 privilege fault wins over a clear present bit, no EXT
        run("R6 priv fail", 3, 2, 1, 3, 'h7FF, mk(64'h0, 16'h8, 0, 4'hE, 0, 0),
            0, 0, 1, 'h1A, 0, 64'h0, 0, 0, 1, 'h18);
        run("R6 external skips priv", 3, 0, 1, 3, 'h7FF, mk(64'h777, 16'h20, 0, 4'h6, 0, 1),
            2, 0, 0, 0, 'h20, 64'h777, 0, 0, 1, 'h18);
        run("R6 prot overflow trap priv", 4, 3, 1, 3, 'h7FF, mk(64'h9999, 16'h30, 0, 4'hE, 2, 1),
            0, 0, 1, 'h22, 0, 64'h0, 0, 0, 1, 'h20);
        run("R6 prot overflow trap ok", 4, 3, 1, 3, 'h7FF, mk(64'h9999, 16'h30, 0, 4'hE, 3, 1),
            2, 0, 0, 0, 'h30, 64'h9999, 0, 0, 1, 'h20);
        run("R7 not present ext", 'h40, 0, 1, 0, 'h7FF, mk(64'h0, 16'h8, 0, 4'hE, 0, 0),
            0, 1, 1, 'h203, 0, 64'h0, 0, 0, 1, 'h200);
        run("R7 not present soft", 'h40, 1, 1, 0, 'h7FF, mk(64'h0, 16'h8, 0, 4'hE, 3, 0),
            0, 1, 1, 'h202, 0, 64'h0, 0, 0, 1, 'h200);
        // R13: task dispatch carries zero offset
        run("R8 R13 task gate", 8, 1, 1, 0, 'h7FF, mk(64'h1111, 16'h28, 0, 4'h5, 0, 1),
            1, 0, 0, 0, 'h28, 64'h0, 0, 0, 1, 'h40);
        run("R9 R11 long gate", 'h80, 1, 2, 0, 'hFFF,
            mk(64'hFFFF_8000_1234_5678, 16'h10, 3, 4'hE, 0, 1),
            2, 0, 0, 0, 'h10, 64'hFFFF_8000_1234_5678, 1, 3, 1, 'h800);
        run("R9 long task invalid", 2, 0, 2, 0, 'hFFF, mk(64'h0, 16'h8, 0, 4'h5, 0, 1),
            0, 0, 1, 'h23, 0, 64'h0, 0, 0, 1, 'h20);
        run("R9 long limit fail", 'h10, 1, 2, 0, 'h10E, mk(64'h55, 16'h8, 0, 4'hF, 0, 1),
            0, 0, 1, 'h102, 0, 64'h0, 0, 0, 0, 0);
        run("R9 long limit edge", 'h10, 1, 2, 0, 'h10F, mk(64'h55, 16'h8, 0, 4'hF, 0, 1),
            2, 0, 0, 0, 'h8, 64'h55, 0, 0, 1, 'h100);
        run("R10 long overflow trap", 4, 3, 2, 3, 'hFFF, mk(64'h0, 16'h8, 0, 4'hE, 0, 0),
            0, 2, 0, 0, 0, 64'h0, 0, 0, 1, 'h40);
        run("R10 overflow trap bad type", 4, 3, 2, 3, 'hFFF, mk(64'h0, 16'h8, 0, 4'h6, 0, 1),
            0, 0, 1, 'h42, 0, 64'h0, 0, 0, 1, 'h40);
        run("R11 long trap no ist", 1, 0, 2, 0, 'hFFF, mk(64'h1, 16'h8, 0, 4'hF, 0, 1),
            2, 0, 0, 0, 'h8, 64'h1, 0, 0, 1, 'h10);
        run("R11 prot ist ignored", 1, 0, 1, 0, 'hFF, mk(64'h2, 16'h8, 5, 4'hE, 0, 1),
            2, 0, 0, 0, 'h8, 64'h2, 0, 0, 1, 'h8);

        repeat (3) @(negedge clk);
        chk("R12 pending results", 128'(exp_q.size()), 128'(0));
        finish_run();
    end
endmodule